// File: doc/BRIEF.md
# Fixed-Point Status Flag Updater

This block derives the integer status bits that follow a fixed-point operation: carry, low-half carry, overflow, low-half overflow, the sticky summary-overflow bit, and the four-bit condition field that a record form writes. It does not perform the arithmetic. Instead, it looks at the operands that went into the operation and at the result that came out. The operands are up to two register values and an optional immediate. The unit that performed the operation presents them together with its control bits, and pulses `valid_i` for one cycle.

Carry is not taken from the adder. It is inferred: if any operand, compared unsigned, is larger than the result, a wrap-around happened. Overflow uses the usual sign rule on the first two operands. A divide unit can override that rule with its own overflow verdict. All status state is held in registers inside the block. Each bit keeps its value until an operation with the matching enable rewrites it.

Top module: `fxf_flag_update`

## Requirements
- R1: While `rst_ni` is low, every output is 0.
- R2: A cycle with `valid_i` low changes no output on the following edge.
- R3: Operands are placed in the order a, b, immediate, and only the ones whose valid input is high are kept. The first operand kept is bitwise inverted when `inv_a_i` is high. This happens before any carry or overflow test. An immediate with `imm_vld_i` high is always the last operand.
- R4: The new carry is 1 when at least one kept operand, read as unsigned DW bits, is greater than `res_i`. With no operand kept, it is 0.
- R5: The new low-half carry applies the R4 test to the low HW bits of each operand and of the result.
- R6: `ca_o` is written one cycle after a valid strobe only if `ca_en_i` is 1 and `ca_done_i` is 0. `ca32_o` is written under the same rule, using `ca32_done_i` in place of `ca_done_i`. Otherwise each bit holds.
- R7: The overflow rule sets the bit when the first two kept operands have equal sign bits and the result's sign bit differs from them. `ov_o` uses bit DW-1 as the sign; `ov32_o` uses bit HW-1.
- R8: When `div_ov_vld_i` is 1, both `ov_o` and `ov32_o` take `div_ov_i`, replacing the R7 rule.
- R9: Both overflow bits are written only when `ov_en_i` and `ov_ok_i` are both 1, and also either at least two operands are kept or `div_ov_vld_i` is 1. Otherwise both bits hold.
- R10: Whenever the overflow bits are written, `so_o` becomes its old value ORed with the new `ov_o`. No valid operation clears `so_o`.
- R11: With `rc_en_i` at 1, `cr0_o` is written as {negative, positive, zero, so}. Bit 3 is the result's sign (signed DW bits), bit 2 is set when the result is above zero, bit 1 is set when it equals zero, and bit 0 is `so_o` after this operation's update. With `rc_en_i` at 0, `cr0_o` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | One operation's inputs are present this cycle |
| a_i | input | DW | First register operand |
| a_vld_i | input | 1 | a_i takes part |
| b_i | input | DW | Second register operand |
| b_vld_i | input | 1 | b_i takes part |
| imm_i | input | DW | Immediate operand |
| imm_vld_i | input | 1 | imm_i takes part |
| inv_a_i | input | 1 | Invert the first kept operand |
| res_i | input | DW | Result of the operation |
| ca_en_i | input | 1 | Carry outputs may be written |
| ca_done_i | input | 1 | Operation wrote carry itself; skip it |
| ca32_done_i | input | 1 | Operation wrote low-half carry itself; skip it |
| ov_en_i | input | 1 | Overflow enable |
| ov_ok_i | input | 1 | Overflow enable is valid |
| div_ov_vld_i | input | 1 | Divide-supplied overflow is present |
| div_ov_i | input | 1 | Divide-supplied overflow value |
| rc_en_i | input | 1 | Record: write the condition field |
| ca_o | output | 1 | Carry |
| ca32_o | output | 1 | Low-half carry |
| ov_o | output | 1 | Overflow |
| ov32_o | output | 1 | Low-half overflow |
| so_o | output | 1 | Sticky summary overflow |
| cr0_o | output | 4 | Condition field {lt, gt, eq, so} |

## Verification
The bench builds the block with DW = 8 and HW = 4. At these widths it can apply every pair of a and b values, 65,536 combinations. A hash of each pair chooses the valid bits, the enables, the immediate and which result shape is presented. The result is one of four shapes: a sum, a difference, a scrambled value, or a plain echo. Because of this, every carry, wrap and sign-overflow boundary is reached at both the full and the half width.

The bench resets the block at the start of each row. This lets the sticky bit be seen rising from zero many times, instead of staying set after the first overflow.

// File: rtl/fxf_pkg.sv
package fxf_pkg;
  localparam int NUM_SLOTS = 3;

  typedef struct packed {
    logic       ca;
    logic       ca32;
    logic       ov;
    logic       ov32;
    logic       so;
    logic [3:0] cr;
  } fxf_state_t;

  localparam int CR_LT = 3;
  localparam int CR_GT = 2;
  localparam int CR_EQ = 1;
  localparam int CR_SO = 0;
endpackage

// File: rtl/fxf_operand_prep.sv
module fxf_operand_prep
  import fxf_pkg::*;
#(
  parameter int DW = 64
) (
  input  logic                          a_vld_i,
  input  logic [DW-1:0]                 a_i,
  input  logic                          b_vld_i,
  input  logic [DW-1:0]                 b_i,
  input  logic                          imm_vld_i,
  input  logic [DW-1:0]                 imm_i,
  input  logic                          inv_i,
  output logic [NUM_SLOTS-1:0][DW-1:0]  ops_o,
  output logic [NUM_SLOTS-1:0]          vld_o
);
  logic [DW-1:0] slot0;

  // pack kept operands toward slot 0, order a, b, imm
  always_comb begin
    slot0    = a_vld_i ? a_i : (b_vld_i ? b_i : imm_i);
    vld_o[0] = a_vld_i | b_vld_i | imm_vld_i;
    ops_o[0] = inv_i ? ~slot0 : slot0;
    ops_o[1] = (a_vld_i && b_vld_i) ? b_i : imm_i;
    vld_o[1] = a_vld_i ? (b_vld_i | imm_vld_i) : (b_vld_i & imm_vld_i);
    ops_o[2] = imm_i;
    vld_o[2] = a_vld_i & b_vld_i & imm_vld_i;
  end
endmodule

// File: rtl/fxf_carry_detect.sv
module fxf_carry_detect
  import fxf_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [NUM_SLOTS-1:0][W-1:0] ops_i,
  input  logic [NUM_SLOTS-1:0]        vld_i,
  input  logic [W-1:0]                res_i,
  output logic                        cy_o
);
  logic [NUM_SLOTS-1:0] gt;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    assign gt[i] = vld_i[i] && (ops_i[i] > res_i);
  end

  assign cy_o = |gt;
endmodule

// File: rtl/fxf_overflow_detect.sv
module fxf_overflow_detect #(
  parameter int LANES = 2
) (
  input  logic [LANES-1:0] s0_i,
  input  logic [LANES-1:0] s1_i,
  input  logic [LANES-1:0] sr_i,
  input  logic             div_vld_i,
  input  logic             div_ov_i,
  output logic [LANES-1:0] ov_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic rule;
    assign rule    = (s0_i[l] == s1_i[l]) && (sr_i[l] != s0_i[l]);
    assign ov_o[l] = div_vld_i ? div_ov_i : rule;
  end
endmodule

// File: rtl/fxf_flag_update.sv
module fxf_flag_update
  import fxf_pkg::*;
#(
  parameter int DW = 64,
  parameter int HW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [DW-1:0] a_i,
  input  logic          a_vld_i,
  input  logic [DW-1:0] b_i,
  input  logic          b_vld_i,
  input  logic [DW-1:0] imm_i,
  input  logic          imm_vld_i,
  input  logic          inv_a_i,
  input  logic [DW-1:0] res_i,
  input  logic          ca_en_i,
  input  logic          ca_done_i,
  input  logic          ca32_done_i,
  input  logic          ov_en_i,
  input  logic          ov_ok_i,
  input  logic          div_ov_vld_i,
  input  logic          div_ov_i,
  input  logic          rc_en_i,
  output logic          ca_o,
  output logic          ca32_o,
  output logic          ov_o,
  output logic          ov32_o,
  output logic          so_o,
  output logic [3:0]    cr0_o
);
  localparam int SGN_F = DW - 1;
  localparam int SGN_H = HW - 1;

  logic [NUM_SLOTS-1:0][DW-1:0] ops;
  logic [NUM_SLOTS-1:0][HW-1:0] ops_lo;
  logic [NUM_SLOTS-1:0]         ops_vld;
  logic                         cy_full, cy_half;
  logic [1:0]                   ov_lane;
  fxf_state_t                   st_q, st_d;

  fxf_operand_prep #(.DW(DW)) u_prep (
    .a_vld_i   (a_vld_i),
    .a_i       (a_i),
    .b_vld_i   (b_vld_i),
    .b_i       (b_i),
    .imm_vld_i (imm_vld_i),
    .imm_i     (imm_i),
    .inv_i     (inv_a_i),
    .ops_o     (ops),
    .vld_o     (ops_vld)
  );

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_lo
    assign ops_lo[i] = ops[i][HW-1:0];
  end

  fxf_carry_detect #(.W(DW)) u_cy_full (
    .ops_i (ops),
    .vld_i (ops_vld),
    .res_i (res_i),
    .cy_o  (cy_full)
  );

  fxf_carry_detect #(.W(HW)) u_cy_half (
    .ops_i (ops_lo),
    .vld_i (ops_vld),
    .res_i (res_i[HW-1:0]),
    .cy_o  (cy_half)
  );

  // lane 1: full width, lane 0: low half
  fxf_overflow_detect #(.LANES(2)) u_ov (
    .s0_i      ({ops[0][SGN_F], ops[0][SGN_H]}),
    .s1_i      ({ops[1][SGN_F], ops[1][SGN_H]}),
    .sr_i      ({res_i[SGN_F], res_i[SGN_H]}),
    .div_vld_i (div_ov_vld_i),
    .div_ov_i  (div_ov_i),
    .ov_o      (ov_lane)
  );

  logic ov_wr;
  logic res_neg, res_zero;

  assign ov_wr    = ov_en_i && ov_ok_i && (ops_vld[1] || div_ov_vld_i);
  assign res_neg  = res_i[SGN_F];
  assign res_zero = (res_i == '0);

  always_comb begin
    st_d = st_q;
    if (ca_en_i) begin
      if (!ca_done_i)   st_d.ca   = cy_full;
      if (!ca32_done_i) st_d.ca32 = cy_half;
    end
    if (ov_wr) begin
      st_d.ov   = ov_lane[1];
      st_d.ov32 = ov_lane[0];
      st_d.so   = st_q.so | ov_lane[1];
    end
    if (rc_en_i) begin
      st_d.cr[CR_LT] = res_neg;
      st_d.cr[CR_GT] = !res_neg && !res_zero;
      st_d.cr[CR_EQ] = res_zero;
      st_d.cr[CR_SO] = st_d.so;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      st_q <= '0;
    else if (valid_i) st_q <= st_d;
  end

  assign ca_o   = st_q.ca;
  assign ca32_o = st_q.ca32;
  assign ov_o   = st_q.ov;
  assign ov32_o = st_q.ov32;
  assign so_o   = st_q.so;
  assign cr0_o  = st_q.cr;
endmodule

// File: rtl/fxf_flag_update_chk.sv
module fxf_flag_update_chk #(
  parameter int DW = 64
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_i,
  input logic [DW-1:0] res_i,
  input logic          ca_en_i,
  input logic          ca_done_i,
  input logic          ca32_done_i,
  input logic          ov_en_i,
  input logic          ov_ok_i,
  input logic          div_ov_vld_i,
  input logic          div_ov_i,
  input logic          rc_en_i,
  input logic          ca_o,
  input logic          ca32_o,
  input logic          ov_o,
  input logic          ov32_o,
  input logic          so_o,
  input logic [3:0]    cr0_o
);
  assert_idle_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable({ca_o, ca32_o, ov_o, ov32_o, so_o, cr0_o}));

  assert_ca_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (!ca_en_i || ca_done_i) |=> $stable(ca_o));

  assert_ca32_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (!ca_en_i || ca32_done_i) |=> $stable(ca32_o));

  assert_div_override_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && ov_en_i && ov_ok_i && div_ov_vld_i |=>
      (ov_o == $past(div_ov_i)) && (ov32_o == $past(div_ov_i)));

  assert_ov_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !(ov_en_i && ov_ok_i) |=> $stable({ov_o, ov32_o, so_o}));

  assert_so_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    so_o |=> so_o);

  assert_cr_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !rc_en_i |=> $stable(cr0_o));

  assert_cr_so_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && rc_en_i |=> cr0_o[0] == so_o);

  assert_cr_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && rc_en_i && (res_i == '0) |=> cr0_o[3:1] == 3'b001);
endmodule

bind fxf_flag_update fxf_flag_update_chk #(.DW(DW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .valid_i      (valid_i),
  .res_i        (res_i),
  .ca_en_i      (ca_en_i),
  .ca_done_i    (ca_done_i),
  .ca32_done_i  (ca32_done_i),
  .ov_en_i      (ov_en_i),
  .ov_ok_i      (ov_ok_i),
  .div_ov_vld_i (div_ov_vld_i),
  .div_ov_i     (div_ov_i),
  .rc_en_i      (rc_en_i),
  .ca_o         (ca_o),
  .ca32_o       (ca32_o),
  .ov_o         (ov_o),
  .ov32_o       (ov32_o),
  .so_o         (so_o),
  .cr0_o        (cr0_o)
);

// File: tb/fxf_flag_update_tb.sv
`timescale 1ns/1ps
module fxf_flag_update_tb;
  localparam int DW = 8;
  localparam int HW = 4;
  localparam int MSK = (1 << DW) - 1;
  localparam int HMSK = (1 << HW) - 1;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 1'b0;
  logic [DW-1:0] a_i = '0, b_i = '0, imm_i = '0, res_i = '0;
  logic a_vld_i = 0, b_vld_i = 0, imm_vld_i = 0, inv_a_i = 0;
  logic ca_en_i = 0, ca_done_i = 0, ca32_done_i = 0;
  logic ov_en_i = 0, ov_ok_i = 0, div_ov_vld_i = 0, div_ov_i = 0, rc_en_i = 0;
  logic ca_o, ca32_o, ov_o, ov32_o, so_o;
  logic [3:0] cr0_o;

  int vectors = 0;
  int miscompares = 0;

  bit e_ca, e_ca32, e_ov, e_ov32, e_so;
  bit [3:0] e_cr;

  always #2.5 clk = ~clk;

  fxf_flag_update #(.DW(DW), .HW(HW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i),
    .a_i(a_i), .a_vld_i(a_vld_i), .b_i(b_i), .b_vld_i(b_vld_i),
    .imm_i(imm_i), .imm_vld_i(imm_vld_i), .inv_a_i(inv_a_i), .res_i(res_i),
    .ca_en_i(ca_en_i), .ca_done_i(ca_done_i), .ca32_done_i(ca32_done_i),
    .ov_en_i(ov_en_i), .ov_ok_i(ov_ok_i), .div_ov_vld_i(div_ov_vld_i),
    .div_ov_i(div_ov_i), .rc_en_i(rc_en_i),
    .ca_o(ca_o), .ca32_o(ca32_o), .ov_o(ov_o), .ov32_o(ov32_o),
    .so_o(so_o), .cr0_o(cr0_o)
  );

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual=hung expected=done");
    summary();
  end

  task automatic cmp_bit(string tag, bit act, bit exp, ref bit bad);
    if (act !== exp) begin
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      bad = 1;
    end
  endtask

  task automatic compare_all();
    bit bad = 0;
    vectors++;
    cmp_bit("ca R2 R3 R4 R6", ca_o, e_ca, bad);
    cmp_bit("ca32 R5 R6", ca32_o, e_ca32, bad);
    cmp_bit("ov R7 R8 R9", ov_o, e_ov, bad);
    cmp_bit("ov32 R7 R8 R9", ov32_o, e_ov32, bad);
    cmp_bit("so R10", so_o, e_so, bad);
    if (cr0_o !== e_cr) begin
      $display("FAIL cr0 R11: actual=%b expected=%b", cr0_o, e_cr);
      bad = 1;
    end
    if (bad) miscompares++;
  endtask

  // R1: reset clears every output
  task automatic do_reset();
    valid_i = 0;
    rst_ni  = 0;
    #1;
    {e_ca, e_ca32, e_ov, e_ov32, e_so} = '0;
    e_cr = '0;
    vectors++;
    if ({ca_o, ca32_o, ov_o, ov32_o, so_o, cr0_o} !== 9'd0) begin
      $display("FAIL reset R1: actual=%b expected=0",
               {ca_o, ca32_o, ov_o, ov32_o, so_o, cr0_o});
      miscompares++;
    end
    @(negedge clk);
    rst_ni = 1;
  endtask

  task automatic model_step();
    int ops[3];
    int n = 0;
    bit cy = 0, cy32 = 0, nov, nov32;
    int r = int'(res_i);
    if (!valid_i) return;
    if (a_vld_i)   begin ops[n] = int'(a_i);   n++; end
    if (b_vld_i)   begin ops[n] = int'(b_i);   n++; end
    if (imm_vld_i) begin ops[n] = int'(imm_i); n++; end
    if (inv_a_i && n > 0) ops[0] = (~ops[0]) & MSK;
    for (int i = 0; i < n; i++) begin
      if (ops[i] > r) cy = 1;
      if ((ops[i] & HMSK) > (r & HMSK)) cy32 = 1;
    end
    if (ca_en_i) begin
      if (!ca_done_i)   e_ca = cy;
      if (!ca32_done_i) e_ca32 = cy32;
    end
    if (ov_en_i && ov_ok_i && (n >= 2 || div_ov_vld_i)) begin
      if (div_ov_vld_i) begin
        nov = div_ov_i; nov32 = div_ov_i;
      end else begin
        nov   = (ops[0][DW-1] == ops[1][DW-1]) && (r[DW-1] != ops[0][DW-1]);
        nov32 = (ops[0][HW-1] == ops[1][HW-1]) && (r[HW-1] != ops[0][HW-1]);
      end
      e_ov = nov; e_ov32 = nov32; e_so = e_so | nov;
    end
    if (rc_en_i) begin
      e_cr[3] = r[DW-1];
      e_cr[2] = !r[DW-1] && (r != 0);
      e_cr[1] = (r == 0);
      e_cr[0] = e_so;
    end
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        int h;
        if (b == 0) do_reset();
        h = ((a * 131) ^ (b * 29) ^ (a * b * 7) ^ (b << 9)) & 16'hFFFF;
        a_i = a[7:0];
        b_i = b[7:0];
        imm_i = h[15:8] ^ 8'h5A;
        case (h[1:0])
          2'd0: res_i = DW'(a + b);
          2'd1: res_i = DW'(a - b);
          2'd2: res_i = h[15:8];
          default: res_i = (h[3]) ? a[7:0] : 8'h00;
        endcase
        valid_i      = h[2] | h[3] | h[6];
        a_vld_i      = h[4] | h[9];
        b_vld_i      = h[5] | h[10];
        imm_vld_i    = h[6];
        inv_a_i      = h[7];
        ca_en_i      = h[8] | h[11];
        ca_done_i    = h[12] & h[13];
        ca32_done_i  = h[13] & h[14];
        ov_en_i      = h[11] | h[15];
        ov_ok_i      = h[3] | h[9] | h[14];
        div_ov_vld_i = h[0] & h[12];
        div_ov_i     = h[10];
        rc_en_i      = h[1] | h[14];
        model_step();
        @(negedge clk);
        compare_all();
      end
    end
    summary();
  end
endmodule